// File: doc/BRIEF.md
# Touchscreen ADC Serial Responder

This block is the device side of a 12-bit, eight-channel touchscreen converter that sits on a byte-wide serial link. Each time the link controller finishes a byte exchange, it pulses a strobe. The responder then works out the byte that the device presents for the next exchange. That byte stays on its output until the next strobe.

The host starts a reading by sending a byte with its top bit set. This byte is a command: it picks a channel and restarts the readout. The following two exchanges return the channel's 12-bit sample. The first byte holds the upper seven bits, right-aligned. The second byte holds the lower five bits in its top five positions, with three zero bits below them. After that the output is zero until a new command arrives. A command is accepted at any point in a readout and restarts it. The bus controller can also erase the latched command through a separate clear input. Real conversion is not performed: each channel returns a fixed value.

Top module: `tsc_adc_responder`

## Requirements
- R1: After reset the output byte is 0x00, no command is latched and the readout position is zero, so a first strobe with a non-command byte returns 0x00.
- R2: The output byte changes only in the cycle after a strobe; without a strobe it holds its value, including while the clear input is pulsed.
- R3: A host byte with bit 7 set, seen at a strobe, is latched as the command and resets the readout position to zero. The output byte of that same strobe is first computed from the state that existed before the latch. A host byte with bit 7 clear never changes the latched command.
- R4: At position zero with a command latched, a strobe captures the selected channel's 12-bit sample. It outputs sample bits [11:5] in output bits [6:0], with bit 7 at zero, and moves to position 7.
- R5: At position 7, a strobe outputs the captured sample bits [4:0] in output bits [7:3], with bits [2:0] at zero, and moves to position 12.
- R6: At position 12, and at position zero with no command latched, a strobe outputs 0x00 and leaves the position unchanged.
- R7: The command's bits [6:4] pick the channel, coded 0 temperature A, 1 Y position, 2 battery, 3 pressure 1, 4 pressure 2, 5 X position, 6 auxiliary input, 7 temperature B. The Y position channel returns 0xFFF and every other channel returns 0x000.
- R8: The clear input erases the latched command without moving the readout position. A command byte strobed in the same cycle as a clear is still latched.
- R9: The second byte of a readout comes from the sample captured at the first byte. It is returned even if the command was cleared between the two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_done | input | 1 | One-cycle pulse: a byte exchange has completed |
| host_byte | input | 8 | Byte the host shifted out in the completed exchange |
| ctrl_clear | input | 1 | Erases the latched command |
| dev_byte | output | 8 | Byte the device presents for the next exchange |

## Verification
The readout is run with commands for all eight channels. Each command is followed by two data bytes. Only the Y channel returns nonzero halves, so this sweep shows whether the channel field is decoded correctly and whether the 7/5 split is placed correctly. Other patterns test when a command takes effect:
- a command sent in the middle of a readout,
- two commands sent back to back,
- data bytes with bit 7 clear but other bits set.

These show whether the output is computed before the latch, and whether non-commands are ignored. Clear pulses are placed in three spots: before a readout, between its two bytes, and in the same cycle as a command. Together they separate erasing the command from resetting the position.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Channel codes carried in the command byte's select field.
  typedef enum logic [2:0] {
    CH_TEMP_A = 3'd0,
    CH_Y_POS  = 3'd1,
    CH_BATT   = 3'd2,
    CH_PRES_1 = 3'd3,
    CH_PRES_2 = 3'd4,
    CH_X_POS  = 3'd5,
    CH_AUX    = 3'd6,
    CH_TEMP_B = 3'd7
  } chan_e;

  localparam int unsigned CHAN_COUNT = 8;
  localparam int unsigned CHAN_SEL_W = 3;

  // Fixed stand-in source: only the Y position channel reads full scale.
  function automatic logic chan_full_scale(input chan_e ch);
    return ch == CH_Y_POS;
  endfunction

endpackage

// File: rtl/tsc_sample_src.sv
module tsc_sample_src #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  tsc_pkg::chan_e       sel,
  output logic [SAMPLE_W-1:0]  sample
);
  import tsc_pkg::*;

  logic [SAMPLE_W-1:0] level [CHAN_COUNT];

  for (genvar g = 0; g < int'(CHAN_COUNT); g++) begin : g_chan
    assign level[g] = chan_full_scale(chan_e'(g)) ? {SAMPLE_W{1'b1}} : {SAMPLE_W{1'b0}};
  end

  assign sample = level[sel];

endmodule

// File: rtl/tsc_ctrl_latch.sv
module tsc_ctrl_latch #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [BYTE_W-1:0] host_byte,
  input  logic              clear,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              ctrl_valid,
  output logic              ctrl_load
);

  localparam int unsigned CMD_BIT = BYTE_W - 1;

  function automatic logic is_command(input logic [BYTE_W-1:0] b);
    return b[CMD_BIT];
  endfunction

  assign ctrl_load = strobe && is_command(host_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ctrl_valid <= 1'b0;
    end else if (ctrl_load) begin
      ctrl_q     <= host_byte;
      ctrl_valid <= 1'b1;
    end else if (clear) begin
      ctrl_valid <= 1'b0;
    end
  end

  assert_clear_erases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !ctrl_load) |=> !ctrl_valid);

  assert_clear_loses_to_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && ctrl_load) |=> ctrl_valid);

  assert_cmd_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> (ctrl_valid && ctrl_q == $past(host_byte)));

  assert_data_keeps_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !ctrl_load) |=> $stable(ctrl_q));

endmodule

// File: rtl/tsc_readout.sv
module tsc_readout #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned HI_BITS  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                ctrl_valid,
  input  logic                restart,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [BYTE_W-1:0]   dout,
  output logic                hi_emit,
  output logic                lo_emit
);

  localparam int unsigned LO_BITS = SAMPLE_W - HI_BITS;
  localparam int unsigned POS_W   = $clog2(SAMPLE_W + 1);
  localparam logic [POS_W-1:0] POS_IDLE = '0;
  localparam logic [POS_W-1:0] POS_MID  = POS_W'(HI_BITS);
  localparam logic [POS_W-1:0] POS_END  = POS_W'(SAMPLE_W);

  function automatic logic [BYTE_W-1:0] hi_part(input logic [SAMPLE_W-1:0] s);
    logic [BYTE_W-1:0] r;
    r = '0;
    r[HI_BITS-1:0] = s[SAMPLE_W-1 -: HI_BITS];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] lo_part(input logic [SAMPLE_W-1:0] s);
    logic [BYTE_W-1:0] r;
    r = '0;
    r[BYTE_W-1 -: LO_BITS] = s[LO_BITS-1:0];
    return r;
  endfunction

  logic [POS_W-1:0]    pos_q, pos_d;
  logic [SAMPLE_W-1:0] cap_q, cap_d;
  logic [BYTE_W-1:0]   dout_d;

  always_comb begin
    hi_emit = strobe && (pos_q == POS_IDLE) && ctrl_valid;
    lo_emit = strobe && (pos_q != POS_IDLE) && (pos_q < POS_END);
    pos_d   = pos_q;
    cap_d   = cap_q;
    dout_d  = dout;
    if (strobe) begin
      dout_d = '0;
      if (hi_emit) begin
        cap_d  = sample_in;
        dout_d = hi_part(sample_in);
        pos_d  = POS_MID;
      end else if (lo_emit) begin
        dout_d = lo_part(cap_q);
        pos_d  = POS_END;
      end
      if (restart) pos_d = POS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= POS_IDLE;
      cap_q <= '0;
      dout  <= '0;
    end else begin
      pos_q <= pos_d;
      cap_q <= cap_d;
      dout  <= dout_d;
    end
  end

  assert_pos_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == POS_IDLE) || (pos_q == POS_MID) || (pos_q == POS_END));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(dout));

  assert_end_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && pos_q == POS_END) |=> (dout == '0));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && pos_q == POS_IDLE && !ctrl_valid) |=> (dout == '0));

  assert_hi_to_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_emit && !restart) |=> (pos_q == POS_MID));

  assert_lo_to_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_emit && !restart) |=> (pos_q == POS_END));

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pos_q == POS_IDLE));

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_emit, lo_emit}));

endmodule

// File: rtl/tsc_adc_responder.sv
module tsc_adc_responder #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned HI_BITS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] host_byte,
  input  logic              ctrl_clear,
  output logic [BYTE_W-1:0] dev_byte
);
  import tsc_pkg::*;

  localparam int unsigned SEL_LSB = BYTE_W - 1 - CHAN_SEL_W;

  logic [BYTE_W-1:0]   ctrl_q;
  logic                ctrl_valid;
  logic                ctrl_load;
  chan_e               chan_sel;
  logic [SAMPLE_W-1:0] chan_sample;
  logic                hi_emit;
  logic                lo_emit;

  tsc_ctrl_latch #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (byte_done),
    .host_byte (host_byte),
    .clear     (ctrl_clear),
    .ctrl_q    (ctrl_q),
    .ctrl_valid(ctrl_valid),
    .ctrl_load (ctrl_load)
  );

  assign chan_sel = chan_e'(ctrl_q[SEL_LSB +: CHAN_SEL_W]);

  tsc_sample_src #(.SAMPLE_W(SAMPLE_W)) u_src (
    .sel   (chan_sel),
    .sample(chan_sample)
  );

  tsc_readout #(
    .BYTE_W  (BYTE_W),
    .SAMPLE_W(SAMPLE_W),
    .HI_BITS (HI_BITS)
  ) u_readout (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (byte_done),
    .ctrl_valid(ctrl_valid),
    .restart   (ctrl_load),
    .sample_in (chan_sample),
    .dout      (dev_byte),
    .hi_emit   (hi_emit),
    .lo_emit   (lo_emit)
  );

  assert_event_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_emit || lo_emit) |-> byte_done);

endmodule

// File: tb/tsc_adc_responder_tb_top.sv
`timescale 1ns/1ps
module tsc_adc_responder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_done;
  logic [7:0] host_byte;
  logic       ctrl_clear;
  logic [7:0] dev_byte;

  always #10 clk = ~clk;

  tsc_adc_responder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done),
    .host_byte (host_byte),
    .ctrl_clear(ctrl_clear),
    .dev_byte  (dev_byte)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Behavioural reference state
  int m_pos  = 0;
  bit m_have = 0;
  int m_cmd  = 0;
  int m_smp  = 0;
  int m_out  = 0;

  function automatic int level_of(int ch);
    case (ch)
      1:       return 4095;  // Y position reads full scale
      default: return 0;
    endcase
  endfunction

  task automatic compare(string tag);
    checks++;
    if (dev_byte !== m_out[7:0]) begin
      fails++;
      $display("FAIL %s: dev_byte actual %02h expected %02h", tag, dev_byte, m_out[7:0]);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, advance the model, and compare after the next rising edge.
  task automatic step(bit bd, int hb, bit clr, string tag);
    byte_done  = bd;
    host_byte  = hb[7:0];
    ctrl_clear = clr;
    if (bd) begin
      if (m_pos > 0) begin
        if (m_pos < 12) begin
          m_out = (m_smp % 32) * 8;
          m_pos = 12;
        end else begin
          m_out = 0;
        end
      end else if (m_have) begin
        m_smp = level_of((m_cmd / 16) % 8);
        m_out = m_smp / 32;
        m_pos = 7;
      end else begin
        m_out = 0;
      end
    end
    if (clr) m_have = 0;
    if (bd && hb >= 128) begin
      m_cmd  = hb;
      m_have = 1;
      m_pos  = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog: actual cycles %0d expected below %0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    byte_done  = 1'b0;
    host_byte  = 8'h00;
    ctrl_clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset value");
    step(0, 0, 0, "R1 idle after reset");
    step(1, 8'h00, 0, "R1 no command after reset");
    step(1, 8'h7F, 0, "R6 idle non-command byte");
    step(1, 8'h00, 0, "R3 bit7-clear byte not latched");

    // Y channel readout
    step(1, 8'h90, 0, "R3 command output computed before latch");
    step(1, 8'h00, 0, "R4 high part of Y sample");
    step(0, 0, 0, "R2 hold after high part");
    step(0, 0, 1, "R2 hold during clear");
    step(1, 8'h90, 0, "R3 re-latch Y");
    step(1, 8'h00, 0, "R4 high part again");
    step(1, 8'h00, 0, "R5 low part of Y sample");
    step(0, 0, 0, "R2 hold after low part");
    step(1, 8'h00, 0, "R6 past end zero");
    step(1, 8'h55, 0, "R6 stays at end");

    // Command in mid readout and back-to-back commands
    step(1, 8'h90, 0, "R3 latch Y");
    step(1, 8'hD0, 0, "R3 mid-readout command gives high part");
    step(1, 8'h00, 0, "R7 X channel high part");
    step(1, 8'h00, 0, "R7 X channel low part");
    step(1, 8'h90, 0, "R3 latch Y");
    step(1, 8'h90, 0, "R3 back-to-back command");
    step(1, 8'h00, 0, "R4 after back-to-back restart");
    step(1, 8'h00, 0, "R5 after back-to-back restart");

    // Channel sweep
    for (int ch = 0; ch < 8; ch++) begin
      step(1, 128 + ch * 16 + ch, 0, "R7 sweep command");
      step(1, 8'h00, 0, "R7 sweep high part");
      step(0, 0, 0, "R2 sweep hold");
      step(1, 8'h00, 0, "R7 sweep low part");
    end

    // Clear behaviour
    step(1, 8'h90, 0, "R8 latch before clear");
    step(0, 0, 1, "R8 clear pulse");
    step(1, 8'h00, 0, "R8 cleared command gives zero");
    step(1, 8'h00, 0, "R8 still cleared");
    step(1, 8'h90, 0, "R9 latch Y");
    step(1, 8'h00, 0, "R9 high part");
    step(0, 0, 1, "R9 clear between bytes");
    step(1, 8'h00, 0, "R9 low part survives clear");
    step(1, 8'h00, 0, "R9 then zero");
    step(1, 8'h90, 1, "R8 command with simultaneous clear");
    step(1, 8'h00, 0, "R8 command survived clear");
    step(1, 8'h00, 1, "R8 clear during low-part strobe");
    step(1, 8'h00, 0, "R8 zero after cleared readout");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule